// File: doc/BRIEF.md
# Banked Vector Load Address Sequencer

This block turns one vector load command into a run of single-word read requests for a memory made of sixteen independent banks. The banks are word-interleaved: the low four bits of a word address select the bank. A command gives a base address, a stride and an element count. The block walks the elements in order, and element i sits at base plus i times stride. In gather mode the block adds a per-element offset, taken from an index vector, to the base instead of using the stride.

There is a single request port, so at most one request leaves per cycle. After a bank accepts a request it stays occupied for eleven cycles. The block keeps one countdown timer per bank. When the next element maps to an occupied bank, the block holds that element until the bank frees, so the stride and the bank count decide whether requests leave back to back or with gaps. The memory returns read data in request order. The block labels each returned word with its element number and pulses a completion flag when the run ends.

The control state machine has four states. IDLE waits for a command. ISSUE sends one element per free-bank cycle. DRAIN waits for the outstanding reads to come back. FINISH raises the completion pulse for one cycle. The transitions are named as follows:
- IDLE→ISSUE (start, nonzero count)
- IDLE→FINISH (start, zero count)
- ISSUE→DRAIN (last element sent)
- DRAIN→FINISH (last element's data returned)
- FINISH→IDLE (always)

Top module: `vec_addr_gen`

## Requirements
- R1: A `start` pulse in IDLE latches `gather`, `base`, `stride`, `vlen` and `idx_vec`. A `start` seen while `busy` is high is ignored and does not change the running command.
- R2: In strided mode, element i is requested at address (base + i·stride) mod 2^16. There is at most one request per cycle, and elements are requested in increasing order of i.
- R3: The bank of an address is its bits [3:0]. A bank that receives a request in cycle t accepts no other request until cycle t+11. The sequencer waits on such a bank and does not skip ahead to a later element.
- R4: When the stride is odd, so relatively prime to 16, all elements of a 16-element command are requested in 16 consecutive cycles.
- R5: In gather mode, element i is requested at (base + index_i) mod 2^16. index_i sits in `idx_vec` bits [16i+15:16i].
- R6: Each returned word appears on `res_valid`/`res_data` in the same cycle that `mem_rvalid` is high. `res_idx` counts the returns 0, 1, 2, … in request order.
- R7: `done` is a one-cycle pulse in the cycle after the last element's data returns. `busy` is high from the cycle after the accepted start through the `done` cycle.
- R8: A count of zero raises `done` in the cycle after `start` and makes no request.
- R9: A `vlen` above 16 is treated as 16.
- R10: Address arithmetic wraps modulo 2^16, and no fault is signalled.
- R11: After reset, `busy`, `mem_req`, `res_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Command strobe |
| gather | input | 1 | 1 = index-vector addressing, 0 = strided |
| base | input | 16 | Base word address |
| stride | input | 16 | Element spacing in words |
| vlen | input | 5 | Element count, clamped to 16 |
| idx_vec | input | 256 | Sixteen 16-bit offsets for gather mode |
| mem_req | output | 1 | Read request valid this cycle |
| mem_addr | output | 16 | Read word address |
| mem_rvalid | input | 1 | Read data valid, in request order |
| mem_rdata | input | 32 | Read data |
| res_valid | output | 1 | Result word valid |
| res_idx | output | 4 | Element number of the result |
| res_data | output | 32 | Result word |
| done | output | 1 | Command complete pulse |
| busy | output | 1 | Command in progress |

## Verification
The bench tests strides that collide at different distances: stride 16 hits one bank every time, stride 2 wraps around eight banks just before they free, and a gather index list hits the same bank repeatedly. A sequencer that is off by one on the busy window would either issue into an occupied bank, which the bench memory reports, or open gaps one cycle late. Further cases cover a zero count, an over-long count, addresses that wrap past the top of the space, and a second `start` while a command runs. A design that got these wrong would hang, issue requests it should not, run past 16 elements, or replace the running command. The `res_idx` tags and the `done` cycle are compared against the reference model on every clock, so a tag counter that restarts or a completion that comes a cycle early shows up at once.

// File: rtl/vag_pkg.sv
package vag_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ISSUE  = 2'd1,
        ST_DRAIN  = 2'd2,
        ST_FINISH = 2'd3
    } vag_state_e;
endpackage

// File: rtl/vag_bank_timers.sv
module vag_bank_timers #(
    parameter int NBANK    = 16,
    parameter int BANK_LAT = 11
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     issue,
    input  logic [$clog2(NBANK)-1:0] issue_bank,
    output logic [NBANK-1:0]         bank_busy
);
    localparam int BANK_W = $clog2(NBANK);
    localparam int TMR_W  = $clog2(BANK_LAT + 1);
    localparam logic [TMR_W-1:0] RELOAD = TMR_W'(BANK_LAT - 1);

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        logic [TMR_W-1:0] remain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                remain <= '0;
            else if (issue && issue_bank == BANK_W'(g))
                remain <= RELOAD;
            else if (remain != '0)
                remain <= remain - 1'b1;
        end
        assign bank_busy[g] = (remain != '0);
    end
endmodule

// File: rtl/vag_addr_calc.sv
module vag_addr_calc #(
    parameter int ADDR_W = 16,
    parameter int MAXLEN = 16
) (
    input  logic                       gather,
    input  logic [ADDR_W-1:0]          base,
    input  logic [ADDR_W-1:0]          stride,
    input  logic [MAXLEN*ADDR_W-1:0]   idx_vec,
    input  logic [$clog2(MAXLEN)-1:0]  elem,
    output logic [ADDR_W-1:0]          addr
);
    localparam int IDX_W = $clog2(MAXLEN);

    logic [ADDR_W-1:0] offset;

    always_comb begin
        if (gather)
            offset = idx_vec[elem*ADDR_W +: ADDR_W];
        else
            offset = stride * {{(ADDR_W-IDX_W){1'b0}}, elem};
        addr = base + offset;
    end
endmodule

// File: rtl/vec_addr_gen.sv
module vec_addr_gen
    import vag_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 32,
    parameter int NBANK    = 16,
    parameter int BANK_LAT = 11,
    parameter int MAXLEN   = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic                          gather,
    input  logic [ADDR_W-1:0]             base,
    input  logic [ADDR_W-1:0]             stride,
    input  logic [$clog2(MAXLEN+1)-1:0]   vlen,
    input  logic [MAXLEN*ADDR_W-1:0]      idx_vec,
    output logic                          mem_req,
    output logic [ADDR_W-1:0]             mem_addr,
    input  logic                          mem_rvalid,
    input  logic [DATA_W-1:0]             mem_rdata,
    output logic                          res_valid,
    output logic [$clog2(MAXLEN)-1:0]     res_idx,
    output logic [DATA_W-1:0]             res_data,
    output logic                          done,
    output logic                          busy
);
    localparam int LEN_W  = $clog2(MAXLEN + 1);
    localparam int IDX_W  = $clog2(MAXLEN);
    localparam int BANK_W = $clog2(NBANK);
    localparam logic [LEN_W-1:0] LEN_CAP = LEN_W'(MAXLEN);

    vag_state_e state, state_nx;

    logic [ADDR_W-1:0]        base_q, stride_q;
    logic [MAXLEN*ADDR_W-1:0] idx_q;
    logic                     gather_q;
    logic [LEN_W-1:0]         len_q, iss_cnt, ret_cnt;
    logic [LEN_W-1:0]         len_in;
    logic [ADDR_W-1:0]        cur_addr;
    logic [NBANK-1:0]         bank_busy;
    logic                     accept, issue_ok, last_issue, last_ret, running;

    assign len_in     = (vlen > LEN_CAP) ? LEN_CAP : vlen;
    assign accept     = (state == ST_IDLE) && start;
    assign running    = (state == ST_ISSUE) || (state == ST_DRAIN);
    assign issue_ok   = (state == ST_ISSUE) && !bank_busy[cur_addr[BANK_W-1:0]];
    assign last_issue = (iss_cnt == len_q - 1'b1);
    assign last_ret   = running && mem_rvalid && (ret_cnt == len_q - 1'b1);

    vag_addr_calc #(.ADDR_W(ADDR_W), .MAXLEN(MAXLEN)) u_addr (
        .gather  (gather_q),
        .base    (base_q),
        .stride  (stride_q),
        .idx_vec (idx_q),
        .elem    (iss_cnt[IDX_W-1:0]),
        .addr    (cur_addr)
    );

    vag_bank_timers #(.NBANK(NBANK), .BANK_LAT(BANK_LAT)) u_timers (
        .clk        (clk),
        .rst_n      (rst_n),
        .issue      (issue_ok),
        .issue_bank (cur_addr[BANK_W-1:0]),
        .bank_busy  (bank_busy)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (start) state_nx = (len_in == '0) ? ST_FINISH : ST_ISSUE;
            ST_ISSUE:  if (issue_ok && last_issue) state_nx = ST_DRAIN;
            ST_DRAIN:  if (last_ret) state_nx = ST_FINISH;
            ST_FINISH: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q   <= '0;
            stride_q <= '0;
            idx_q    <= '0;
            gather_q <= 1'b0;
            len_q    <= '0;
            iss_cnt  <= '0;
            ret_cnt  <= '0;
        end else if (accept) begin
            base_q   <= base;
            stride_q <= stride;
            idx_q    <= idx_vec;
            gather_q <= gather;
            len_q    <= len_in;
            iss_cnt  <= '0;
            ret_cnt  <= '0;
        end else begin
            if (issue_ok)              iss_cnt <= iss_cnt + 1'b1;
            if (running && mem_rvalid) ret_cnt <= ret_cnt + 1'b1;
        end
    end

    always_comb begin
        mem_req   = issue_ok;
        mem_addr  = cur_addr;
        res_valid = running && mem_rvalid;
        res_idx   = ret_cnt[IDX_W-1:0];
        res_data  = mem_rdata;
        done      = (state == ST_FINISH);
        busy      = (state != ST_IDLE);
    end
endmodule

// File: rtl/vag_chk.sv
module vag_chk #(
    parameter int ADDR_W = 16,
    parameter int NBANK  = 16,
    parameter int LEN_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [LEN_W-1:0]  vlen,
    input logic              busy,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [NBANK-1:0]  bank_busy,
    input logic              res_valid,
    input logic              done
);
    localparam int BANK_W = $clog2(NBANK);

    // R3
    no_busy_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !bank_busy[mem_addr[BANK_W-1:0]]);

    // R3
    bank_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> bank_busy[$past(mem_addr[BANK_W-1:0])]);

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && vlen == '0) |=> (done && !mem_req));

    // R6
    result_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> busy);

    // R2
    req_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (busy && !done));
endmodule

bind vec_addr_gen vag_chk #(
    .ADDR_W (ADDR_W),
    .NBANK  (NBANK),
    .LEN_W  ($clog2(MAXLEN + 1))
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .vlen      (vlen),
    .busy      (busy),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .bank_busy (bank_busy),
    .res_valid (res_valid),
    .done      (done)
);

// File: tb/tb_vec_addr_gen.sv
`timescale 1ns/1ps
module tb_vec_addr_gen;
    localparam int LAT = 11;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0, gather = 1'b0;
    logic [15:0]  base_in = '0, stride_in = '0;
    logic [4:0]   vlen_in = '0;
    logic [255:0] idx_in = '0;
    logic         mem_req, mem_rvalid, res_valid, done, busy;
    logic [15:0]  mem_addr;
    logic [31:0]  mem_rdata, res_data;
    logic [3:0]   res_idx;

    always #2.5 clk = ~clk;

    vec_addr_gen dut (
        .clk(clk), .rst_n(rst_n), .start(start), .gather(gather),
        .base(base_in), .stride(stride_in), .vlen(vlen_in), .idx_vec(idx_in),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .res_valid(res_valid), .res_idx(res_idx), .res_data(res_data),
        .done(done), .busy(busy)
    );

    int checks = 0, errors = 0, cyc = 0;
    bit finished = 0;

    function automatic logic [31:0] memf(logic [15:0] a);
        return {a ^ 16'h5A3C, a};
    endfunction

    // behavioural memory: fixed latency, in-order, flags requests to occupied banks
    logic        pv [LAT];
    logic [15:0] pa [LAT];
    int          mtmr [16];
    always @(posedge clk) begin
        pv[0] <= mem_req;
        pa[0] <= mem_addr;
        for (int k = 1; k < LAT; k++) begin
            pv[k] <= pv[k-1];
            pa[k] <= pa[k-1];
        end
        cyc <= cyc + 1;
    end
    assign mem_rvalid = rst_n && pv[LAT-1];
    assign mem_rdata  = memf(pa[LAT-1]);

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    // reference model
    int          mst = 0, m_len = 0, m_iss = 0;
    bit          m_g = 0;
    logic [15:0] m_base = '0, m_stride = '0;
    logic [255:0] m_idx = '0;
    int          tmr [16];
    int          q_due [$], q_addr [$], q_idx [$];
    int          req_cnt = 0, first_req = -1, last_req = -1;
    logic [15:0] last_addr = '0;
    bit          seen_done = 0;

    always @(negedge clk) begin
        if (!rst_n) begin
            mst = 0;
            for (int b = 0; b < 16; b++) begin tmr[b] = 0; mtmr[b] = 0; end
            q_due.delete(); q_addr.delete(); q_idx.delete();
        end else begin
            logic [15:0] ea;
            bit er, ev;
            int eidx, eaddr;
            ea = m_g ? (m_base + m_idx[m_iss[3:0]*16 +: 16])
                     : (m_base + m_stride * 16'(m_iss));
            er = (mst == 1) && (tmr[ea[3:0]] == 0);
            ev = (q_due.size() > 0) && (q_due[0] == cyc);
            eidx = ev ? q_idx[0] : 0;
            eaddr = ev ? q_addr[0] : 0;
            // R3 memory-side conflict check
            if (mem_req) check(mtmr[mem_addr[3:0]] == 0, "R3", "request to occupied bank", mtmr[mem_addr[3:0]], 0);
            for (int b = 0; b < 16; b++) if (mtmr[b] > 0) mtmr[b]--;
            if (mem_req) mtmr[mem_addr[3:0]] = LAT - 1;
            check(mem_req == er, "R3", "mem_req", mem_req, er);
            if (er) check(mem_addr == ea, m_g ? "R5" : "R2", "mem_addr", mem_addr, ea);
            check(res_valid == ev, "R6", "res_valid", res_valid, ev);
            if (ev) begin
                check(res_idx == 4'(eidx), "R6", "res_idx", res_idx, eidx);
                check(res_data == memf(16'(eaddr)), "R6", "res_data", res_data, memf(16'(eaddr)));
            end
            check(done == (mst == 3), "R7", "done", done, mst == 3);
            check(busy == (mst != 0), "R7", "busy", busy, mst != 0);
            if (done) seen_done = 1;
            if (mem_req) begin
                req_cnt++;
                if (first_req < 0) first_req = cyc;
                last_req = cyc;
                last_addr = mem_addr;
            end
            // advance model
            for (int b = 0; b < 16; b++) if (tmr[b] > 0) tmr[b]--;
            if (ev) begin
                void'(q_due.pop_front()); void'(q_addr.pop_front()); void'(q_idx.pop_front());
            end
            case (mst)
                0: if (start) begin
                    m_g = gather; m_base = base_in; m_stride = stride_in; m_idx = idx_in;
                    m_len = (vlen_in > 16) ? 16 : int'(vlen_in);
                    m_iss = 0;
                    mst = (m_len == 0) ? 3 : 1;
                end
                1: if (er) begin
                    q_due.push_back(cyc + LAT); q_addr.push_back(int'(ea)); q_idx.push_back(m_iss);
                    tmr[ea[3:0]] = LAT - 1;
                    m_iss++;
                    if (m_iss == m_len) mst = 2;
                end
                2: if (ev && eidx == m_len - 1) mst = 3;
                default: mst = 0;
            endcase
        end
    end

    task automatic run(input bit g, input int b, input int s, input int l, input bit restart);
        @(posedge clk); #1;
        req_cnt = 0; first_req = -1; last_req = -1; seen_done = 0;
        gather = g; base_in = 16'(b); stride_in = 16'(s); vlen_in = 5'(l); start = 1;
        @(posedge clk); #1;
        start = 0;
        if (restart) begin
            // R1: a second command while busy must be ignored
            base_in = 16'h7777; stride_in = 16'd9; vlen_in = 5'd3; gather = ~g;
            repeat (3) begin @(posedge clk); #1 start = 1; end
            start = 0;
        end
        while (!seen_done) @(posedge clk);
        repeat (2) @(posedge clk);
    endtask

    always @(posedge clk) begin
        if (cyc > 20000 && !finished) begin
            errors++;
            $display("FAIL watchdog: run did not complete, actual %0d cycles expected under 20000", cyc);
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R11 reset state
        check(!busy && !mem_req && !res_valid && !done, "R11", "reset outputs",
              {busy, mem_req, res_valid, done}, 0);
        rst_n = 1;
        repeat (2) @(posedge clk);

        // R2 R4 unit stride, 16 elements back to back
        run(0, 16'h0100, 1, 16, 0);
        check(req_cnt == 16, "R2", "request count", req_cnt, 16);
        check(last_req - first_req == 15, "R4", "unit-stride span", last_req - first_req, 15);

        // R4 odd stride 3
        run(0, 16'h0203, 3, 16, 0);
        check(last_req - first_req == 15, "R4", "stride-3 span", last_req - first_req, 15);

        // R3 stride 16: every element in one bank
        run(0, 16'h0040, 16, 4, 0);
        check(last_req - first_req == 33, "R3", "same-bank span", last_req - first_req, 33);

        // R3 stride 2: element 8 waits for bank of element 0
        run(0, 16'h0000, 2, 12, 0);
        check(last_req - first_req == 14, "R3", "stride-2 span", last_req - first_req, 14);

        // R5 gather with colliding indices
        for (int i = 0; i < 16; i++) idx_in[i*16 +: 16] = 16'((i % 2) * 16 + i / 2 + (i % 3) * 32);
        run(1, 16'h1000, 0, 10, 0);
        check(req_cnt == 10, "R5", "gather request count", req_cnt, 10);

        // R8 zero count
        run(0, 16'h0500, 1, 0, 0);
        check(req_cnt == 0, "R8", "zero-length requests", req_cnt, 0);

        // R9 over-long count clamped
        run(0, 16'h0600, 1, 20, 0);
        check(req_cnt == 16, "R9", "clamped request count", req_cnt, 16);

        // R10 wrap past top of address space
        run(0, 16'hFFF8, 5, 8, 0);
        check(last_addr == 16'h001B, "R10", "wrapped last address", last_addr, 16'h001B);

        // R1 start while busy ignored
        run(0, 16'h0300, 1, 6, 1);
        check(req_cnt == 6, "R1", "requests of first command only", req_cnt, 6);

        finished = 1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule